// File: doc/BRIEF.md
# DRAM Bank Timing Checker

This block sits beside a DRAM command bus and only watches it. Each cycle it sees one command slot carrying an operation (idle, activate, read or precharge), a device number and a bank number. For every bank of every device it keeps three saturating age counters: cycles since that bank's last activate, since its last read, and since its last precharge. It also keeps an open-row flag for each bank and one bus-wide age counter for reads. When a command arrives, the checker compares the relevant ages against the minimum spacing parameters. If any rule is broken, it reports one rule code together with the device and bank of the offending command.

Because state is kept per bank, commands to different banks or devices can interleave freely and raise nothing. The only exception is the read-to-read spacing, which belongs to the shared column bus. The checker also predicts the read data return. A fixed number of cycles after each read, equal to the column access latency plus a configurable skew between the command timing reference and the data timing reference, it raises an expected-data strobe tagged with that read's device and bank.

Top module: `dtc_monitor`

## Requirements
- R1: Operation encoding on `cmd_op` is 0 idle, 1 activate, 2 read, 3 precharge. A command that breaks a rule in cycle c is reported in cycle c+1 with `err_valid`=1, `err_dev`/`err_bank` equal to the command's device and bank, and `err_code` chosen from: 1 protocol, 2 activate-to-read, 3 read-to-read, 4 activate-to-precharge, 5 read-to-precharge, 6 activate-to-activate, 7 precharge-to-activate. A command that breaks no rule gives `err_valid`=0.
- R2: After reset, no error and no data strobe are reported. All banks are closed and carry no timing history, so a first activate anywhere is legal and a read to any bank is a protocol error.
- R3: A read to an open bank fewer than T_RCD cycles after that bank's activate gives code 2. Exactly T_RCD cycles is legal.
- R4: Two reads fewer than T_CC cycles apart give code 3, whichever banks or devices they target. Exactly T_CC is legal.
- R5: A precharge fewer than T_RAS cycles after the bank's activate gives code 4. Exactly T_RAS is legal.
- R6: A precharge fewer than T_RDP cycles after the bank's last read gives code 5, when R5 is met. Exactly T_RDP is legal.
- R7: An activate fewer than T_RC cycles after the bank's previous activate gives code 6. An activate fewer than T_RP cycles after the bank's precharge gives code 7. When both are broken, code 6 is reported. Exactly T_RC and T_RP are legal.
- R8: A read to a bank with no open row, or an activate to a bank whose row is open, gives code 1. Code 1 takes priority over every timing code of the same command.
- R9: Activates, reads and precharges to different banks, issued back to back, raise no error as long as each bank's own spacing and the bus-wide read spacing are met.
- R10: For each read in cycle c, `data_expect` is 1 in cycle c+T_CAC+REF_SKEW, with `data_dev`/`data_bank` equal to that read's device and bank. This holds whether or not the read broke a rule. In the cycle before, the strobe is 0.
- R11: Age counters saturate instead of wrapping. After any long idle gap, a bank's spacing rules are still met.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 2 | Observed operation: 0 idle, 1 activate, 2 read, 3 precharge |
| cmd_dev | input | DEV_W | Device number of the command |
| cmd_bank | input | BANK_W | Bank number within the device |
| err_valid | output | 1 | Rule violation by the previous cycle's command |
| err_code | output | 3 | Violated rule code (0 when no violation) |
| err_dev | output | DEV_W | Device of the offending command |
| err_bank | output | BANK_W | Bank of the offending command |
| data_expect | output | 1 | Read data packet is due to start this cycle |
| data_dev | output | DEV_W | Device of the read whose data is due |
| data_bank | output | BANK_W | Bank of the read whose data is due |

## Verification
The violation report and the expected-data strobe are two separate pipelines that can fire in the same cycle for different commands. To provoke this, the bench issues a legal read, then issues a read to a closed bank exactly one cycle before the first read's data is due. In the cycle where both outputs are raised, the bench checks that the error carries the second read's bank with the protocol code, and that the strobe carries the first read's bank. It also checks that the strobe was low one cycle earlier.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_ACT  = 2'd1,
        OP_RD   = 2'd2,
        OP_PRE  = 2'd3
    } dtc_op_e;

    typedef enum logic [2:0] {
        RULE_NONE  = 3'd0,
        RULE_PROTO = 3'd1,
        RULE_RCD   = 3'd2,
        RULE_CC    = 3'd3,
        RULE_RAS   = 3'd4,
        RULE_RDP   = 3'd5,
        RULE_RC    = 3'd6,
        RULE_RP    = 3'd7
    } dtc_rule_e;

    // One flag per rule, evaluated for the command in the current slot.
    typedef struct packed {
        logic proto;
        logic rcd;
        logic cc;
        logic ras;
        logic rdp;
        logic rc;
        logic rp;
    } dtc_viol_t;

    function automatic int dtc_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int dtc_max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Protocol first, then timing rules in the order a command checks them.
    function automatic dtc_rule_e dtc_pick(input dtc_viol_t v);
        if (v.proto)    return RULE_PROTO;
        else if (v.rcd) return RULE_RCD;
        else if (v.cc)  return RULE_CC;
        else if (v.ras) return RULE_RAS;
        else if (v.rdp) return RULE_RDP;
        else if (v.rc)  return RULE_RC;
        else if (v.rp)  return RULE_RP;
        else            return RULE_NONE;
    endfunction

endpackage

// File: rtl/dtc_age_cnt.sv
// Cycles since the last restart, holding at all-ones instead of wrapping.
module dtc_age_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart_i,
    output logic [W-1:0] age_o
);
    localparam logic [W-1:0] AGE_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)
            age_o <= AGE_MAX;
        else if (restart_i)
            age_o <= W'(1);
        else if (age_o != AGE_MAX)
            age_o <= age_o + W'(1);
    end
endmodule

// File: rtl/dtc_bank_track.sv
// Per-bank history: open row flag and three event ages.
module dtc_bank_track #(
    parameter int AGE_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_i,
    input  logic             rd_i,
    input  logic             pre_i,
    output logic             open_o,
    output logic [AGE_W-1:0] age_act_o,
    output logic [AGE_W-1:0] age_rd_o,
    output logic [AGE_W-1:0] age_pre_o
);
    always_ff @(posedge clk) begin
        if (rst)
            open_o <= 1'b0;
        else if (act_i)
            open_o <= 1'b1;
        else if (pre_i)
            open_o <= 1'b0;
    end

    dtc_age_cnt #(.W(AGE_W)) u_age_act (
        .clk(clk), .rst(rst), .restart_i(act_i), .age_o(age_act_o)
    );
    dtc_age_cnt #(.W(AGE_W)) u_age_rd (
        .clk(clk), .rst(rst), .restart_i(rd_i), .age_o(age_rd_o)
    );
    dtc_age_cnt #(.W(AGE_W)) u_age_pre (
        .clk(clk), .rst(rst), .restart_i(pre_i), .age_o(age_pre_o)
    );
endmodule

// File: rtl/dtc_rule_eval.sv
// Combinational rule check of the current command against the chosen bank.
module dtc_rule_eval
    import dtc_pkg::*;
#(
    parameter int AGE_W = 5,
    parameter int T_RCD = 7,
    parameter int T_CC  = 4,
    parameter int T_RAS = 20,
    parameter int T_RDP = 5,
    parameter int T_RC  = 28,
    parameter int T_RP  = 8
) (
    input  dtc_op_e          op_i,
    input  logic             open_i,
    input  logic [AGE_W-1:0] age_act_i,
    input  logic [AGE_W-1:0] age_rd_i,
    input  logic [AGE_W-1:0] age_pre_i,
    input  logic [AGE_W-1:0] bus_rd_age_i,
    output dtc_viol_t        viol_o
);
    localparam logic [AGE_W-1:0] L_RCD = AGE_W'(T_RCD);
    localparam logic [AGE_W-1:0] L_CC  = AGE_W'(T_CC);
    localparam logic [AGE_W-1:0] L_RAS = AGE_W'(T_RAS);
    localparam logic [AGE_W-1:0] L_RDP = AGE_W'(T_RDP);
    localparam logic [AGE_W-1:0] L_RC  = AGE_W'(T_RC);
    localparam logic [AGE_W-1:0] L_RP  = AGE_W'(T_RP);

    always_comb begin
        viol_o = '0;
        unique case (op_i)
            OP_RD: begin
                viol_o.proto = !open_i;
                viol_o.rcd   = open_i && (age_act_i < L_RCD);
                viol_o.cc    = (bus_rd_age_i < L_CC);
            end
            OP_PRE: begin
                viol_o.ras = (age_act_i < L_RAS);
                viol_o.rdp = (age_rd_i < L_RDP);
            end
            OP_ACT: begin
                viol_o.proto = open_i;
                viol_o.rc    = (age_act_i < L_RC);
                viol_o.rp    = (age_pre_i < L_RP);
            end
            default: viol_o = '0;
        endcase
    end
endmodule

// File: rtl/dtc_rd_pipe.sv
// Fixed-latency delay line carrying each read's tag to its data slot.
module dtc_rd_pipe #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic             vld_o,
    output logic [TAG_W-1:0] tag_o
);
    logic             vld_q [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                vld_q[i] <= 1'b0;
                tag_q[i] <= '0;
            end
        end else begin
            vld_q[0] <= vld_i;
            tag_q[0] <= tag_i;
            for (int i = 1; i < DEPTH; i++) begin
                vld_q[i] <= vld_q[i-1];
                tag_q[i] <= tag_q[i-1];
            end
        end
    end

    assign vld_o = vld_q[DEPTH-1];
    assign tag_o = tag_q[DEPTH-1];
endmodule

// File: rtl/dtc_monitor.sv
module dtc_monitor
    import dtc_pkg::*;
#(
    parameter int NUM_DEV  = 2,
    parameter int NUM_BANK = 4,
    parameter int T_RCD    = 7,
    parameter int T_CC     = 4,
    parameter int T_RAS    = 20,
    parameter int T_RDP    = 5,
    parameter int T_RC     = 28,
    parameter int T_RP     = 8,
    parameter int T_CAC    = 8,
    parameter int REF_SKEW = 0,
    localparam int DEV_W   = dtc_idx_w(NUM_DEV),
    localparam int BANK_W  = dtc_idx_w(NUM_BANK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd_op,
    input  logic [DEV_W-1:0]  cmd_dev,
    input  logic [BANK_W-1:0] cmd_bank,
    output logic              err_valid,
    output logic [2:0]        err_code,
    output logic [DEV_W-1:0]  err_dev,
    output logic [BANK_W-1:0] err_bank,
    output logic              data_expect,
    output logic [DEV_W-1:0]  data_dev,
    output logic [BANK_W-1:0] data_bank
);
    localparam int NB       = NUM_DEV * NUM_BANK;
    localparam int IDX_W    = dtc_idx_w(NB);
    localparam int NB_SLOTS = 1 << IDX_W;
    localparam int MAX_T    = dtc_max2(dtc_max2(dtc_max2(T_RCD, T_CC), dtc_max2(T_RAS, T_RDP)),
                                       dtc_max2(T_RC, T_RP));
    localparam int AGE_W    = dtc_idx_w(MAX_T + 1);
    localparam int DATA_LAT = T_CAC + REF_SKEW;
    localparam int TAG_W    = DEV_W + BANK_W;

    dtc_op_e          op;
    logic [IDX_W-1:0] idx;

    assign op  = dtc_op_e'(cmd_op);
    assign idx = IDX_W'(cmd_dev) * IDX_W'(NUM_BANK) + IDX_W'(cmd_bank);

    // Per-bank state, padded to a power of two so any index selects a slot.
    logic             slot_open    [NB_SLOTS];
    logic [AGE_W-1:0] slot_age_act [NB_SLOTS];
    logic [AGE_W-1:0] slot_age_rd  [NB_SLOTS];
    logic [AGE_W-1:0] slot_age_pre [NB_SLOTS];

    for (genvar s = 0; s < NB_SLOTS; s++) begin : g_slot
        if (s < NB) begin : g_live
            logic hit;
            assign hit = (idx == IDX_W'(s));
            dtc_bank_track #(.AGE_W(AGE_W)) u_trk (
                .clk       (clk),
                .rst       (rst),
                .act_i     (hit && (op == OP_ACT)),
                .rd_i      (hit && (op == OP_RD)),
                .pre_i     (hit && (op == OP_PRE)),
                .open_o    (slot_open[s]),
                .age_act_o (slot_age_act[s]),
                .age_rd_o  (slot_age_rd[s]),
                .age_pre_o (slot_age_pre[s])
            );
        end else begin : g_void
            assign slot_open[s]    = 1'b0;
            assign slot_age_act[s] = '1;
            assign slot_age_rd[s]  = '1;
            assign slot_age_pre[s] = '1;
        end
    end

    // Column bus read spacing is shared by every bank.
    logic [AGE_W-1:0] bus_rd_age;
    dtc_age_cnt #(.W(AGE_W)) u_bus_rd (
        .clk       (clk),
        .rst       (rst),
        .restart_i (op == OP_RD),
        .age_o     (bus_rd_age)
    );

    dtc_viol_t viol;
    dtc_rule_e rule_now;

    dtc_rule_eval #(
        .AGE_W (AGE_W),
        .T_RCD (T_RCD),
        .T_CC  (T_CC),
        .T_RAS (T_RAS),
        .T_RDP (T_RDP),
        .T_RC  (T_RC),
        .T_RP  (T_RP)
    ) u_eval (
        .op_i         (op),
        .open_i       (slot_open[idx]),
        .age_act_i    (slot_age_act[idx]),
        .age_rd_i     (slot_age_rd[idx]),
        .age_pre_i    (slot_age_pre[idx]),
        .bus_rd_age_i (bus_rd_age),
        .viol_o       (viol)
    );

    assign rule_now = dtc_pick(viol);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_valid <= 1'b0;
            err_code  <= RULE_NONE;
            err_dev   <= '0;
            err_bank  <= '0;
        end else begin
            err_valid <= (rule_now != RULE_NONE);
            err_code  <= rule_now;
            err_dev   <= cmd_dev;
            err_bank  <= cmd_bank;
        end
    end

    logic [TAG_W-1:0] pipe_tag;
    dtc_rd_pipe #(.DEPTH(DATA_LAT), .TAG_W(TAG_W)) u_pipe (
        .clk   (clk),
        .rst   (rst),
        .vld_i (op == OP_RD),
        .tag_i ({cmd_dev, cmd_bank}),
        .vld_o (data_expect),
        .tag_o (pipe_tag)
    );
    assign {data_dev, data_bank} = pipe_tag;

endmodule

// File: rtl/dtc_monitor_chk.sv
module dtc_monitor_chk #(
    parameter int DEV_W  = 1,
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        cmd_op,
    input logic [DEV_W-1:0]  cmd_dev,
    input logic [BANK_W-1:0] cmd_bank,
    input logic              err_valid,
    input logic [2:0]        err_code,
    input logic [DEV_W-1:0]  err_dev,
    input logic [BANK_W-1:0] err_bank,
    input logic              data_expect
);
    // R1
    err_after_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> ($past(cmd_op) != 2'd0));

    // R1
    err_addr_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> ((err_dev == $past(cmd_dev)) && (err_bank == $past(cmd_bank))));

    // R3, R4
    rd_rule_op_chk: assert property (@(posedge clk) disable iff (rst)
        (err_valid && ((err_code == 3'd2) || (err_code == 3'd3))) |-> ($past(cmd_op) == 2'd2));

    // R5, R6
    pre_rule_op_chk: assert property (@(posedge clk) disable iff (rst)
        (err_valid && ((err_code == 3'd4) || (err_code == 3'd5))) |-> ($past(cmd_op) == 2'd3));

    // R7
    act_rule_op_chk: assert property (@(posedge clk) disable iff (rst)
        (err_valid && ((err_code == 3'd6) || (err_code == 3'd7))) |-> ($past(cmd_op) == 2'd1));

    // R2
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!err_valid && !data_expect));
endmodule

bind dtc_monitor dtc_monitor_chk #(.DEV_W(DEV_W), .BANK_W(BANK_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_op      (cmd_op),
    .cmd_dev     (cmd_dev),
    .cmd_bank    (cmd_bank),
    .err_valid   (err_valid),
    .err_code    (err_code),
    .err_dev     (err_dev),
    .err_bank    (err_bank),
    .data_expect (data_expect)
);

// File: tb/test_dtc_monitor.sv
module test_dtc_monitor;
    localparam int T_RCD = 7;
    localparam int T_CC  = 4;
    localparam int T_RAS = 20;
    localparam int T_RDP = 5;
    localparam int T_RC  = 28;
    localparam int T_RP  = 8;
    localparam int T_CAC = 8;
    localparam int SKEW  = 0;
    localparam int LAT   = T_CAC + SKEW;

    localparam int ACT = 1, RD = 2, PRE = 3;
    localparam int C_NONE = 0, C_PROTO = 1, C_RCD = 2, C_CC = 3,
                   C_RAS = 4, C_RDP = 5, C_RC = 6, C_RP = 7;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] cmd_op;
    logic [0:0] cmd_dev;
    logic [1:0] cmd_bank;
    logic       err_valid;
    logic [2:0] err_code;
    logic [0:0] err_dev;
    logic [1:0] err_bank;
    logic       data_expect;
    logic [0:0] data_dev;
    logic [1:0] data_bank;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    dtc_monitor #(
        .NUM_DEV(2), .NUM_BANK(4),
        .T_RCD(T_RCD), .T_CC(T_CC), .T_RAS(T_RAS), .T_RDP(T_RDP),
        .T_RC(T_RC), .T_RP(T_RP), .T_CAC(T_CAC), .REF_SKEW(SKEW)
    ) i_dtc_monitor (
        .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_dev(cmd_dev), .cmd_bank(cmd_bank),
        .err_valid(err_valid), .err_code(err_code), .err_dev(err_dev), .err_bank(err_bank),
        .data_expect(data_expect), .data_dev(data_dev), .data_bank(data_bank)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act_v, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act_v, exp_v);
        end
    endtask

    task automatic check_err(input int code, input int dev, input int bank, input string req);
        chk(int'(err_valid) == (code != C_NONE ? 1 : 0), req, "err_valid",
            int'(err_valid), (code != C_NONE ? 1 : 0));
        if (code != C_NONE) begin
            chk(int'(err_code) == code, req, "err_code", int'(err_code), code);
            chk(int'(err_dev) == dev,   req, "err_dev",  int'(err_dev),  dev);
            chk(int'(err_bank) == bank, req, "err_bank", int'(err_bank), bank);
        end
    endtask

    task automatic check_data(input bit exp_v, input int dev, input int bank, input string req);
        chk(data_expect == exp_v, req, "data_expect", int'(data_expect), int'(exp_v));
        if (exp_v) begin
            chk(int'(data_dev) == dev,   req, "data_dev",  int'(data_dev),  dev);
            chk(int'(data_bank) == bank, req, "data_bank", int'(data_bank), bank);
        end
    endtask

    // Drive at the current falling edge; return one cycle later, where the
    // report for this command is visible.
    task automatic issue(input int op, input int dev, input int bank);
        cmd_op   = 2'(op);
        cmd_dev  = 1'(dev);
        cmd_bank = 2'(bank);
        @(negedge clk);
        cmd_op = 2'd0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst      = 1'b1;
        cmd_op   = 2'd0;
        cmd_dev  = '0;
        cmd_bank = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic test_reset();
        do_reset();
        idle(1);
        check_err(C_NONE, 0, 0, "R2");
        check_data(1'b0, 0, 0, "R2");
        issue(ACT, 0, 0);                 check_err(C_NONE, 0, 0, "R2");
        do_reset();
        issue(RD, 0, 0);                  check_err(C_PROTO, 0, 0, "R2");
        issue(ACT, 0, 0);                 check_err(C_NONE, 0, 0, "R2");
    endtask

    task automatic test_legal_boundaries();
        do_reset();
        issue(ACT, 1, 2);                 check_err(C_NONE, 1, 2, "R9");
        idle(T_RCD - 1); issue(RD, 1, 2); check_err(C_NONE, 1, 2, "R3");
        idle(T_CC - 1);  issue(RD, 1, 2); check_err(C_NONE, 1, 2, "R4");
        idle(8);         issue(PRE, 1, 2);check_err(C_NONE, 1, 2, "R5");
        idle(T_RP - 1);  issue(ACT, 1, 2);check_err(C_NONE, 1, 2, "R7");
    endtask

    task automatic test_rcd();
        do_reset();
        issue(ACT, 0, 1);
        idle(T_RCD - 2); issue(RD, 0, 1); check_err(C_RCD, 0, 1, "R3");
    endtask

    task automatic test_cc();
        do_reset();
        issue(ACT, 0, 0);
        issue(ACT, 0, 1);
        idle(10);
        issue(RD, 0, 0);                  check_err(C_NONE, 0, 0, "R4");
        idle(T_CC - 2); issue(RD, 0, 1);  check_err(C_CC, 0, 1, "R4");
        idle(T_CC - 1); issue(RD, 0, 0);  check_err(C_NONE, 0, 0, "R4");
    endtask

    task automatic test_ras();
        do_reset();
        issue(ACT, 0, 2);
        idle(T_RAS - 2); issue(PRE, 0, 2); check_err(C_RAS, 0, 2, "R5");
    endtask

    task automatic test_rdp();
        do_reset();
        issue(ACT, 0, 3);
        idle(30); issue(RD, 0, 3);
        idle(T_RDP - 2); issue(PRE, 0, 3); check_err(C_RDP, 0, 3, "R6");
        issue(ACT, 1, 3);
        idle(30); issue(RD, 1, 3);
        idle(T_RDP - 1); issue(PRE, 1, 3); check_err(C_NONE, 1, 3, "R6");
    endtask

    task automatic test_rc_rp();
        do_reset();
        issue(ACT, 1, 1);
        idle(29); issue(PRE, 1, 1);
        idle(T_RP - 2); issue(ACT, 1, 1);  check_err(C_RP, 1, 1, "R7");
        issue(ACT, 1, 2);
        idle(T_RAS - 1); issue(PRE, 1, 2);
        idle(5); issue(ACT, 1, 2);         check_err(C_RC, 1, 2, "R7");
    endtask

    task automatic test_proto();
        do_reset();
        issue(RD, 1, 2);                  check_err(C_PROTO, 1, 2, "R8");
        issue(ACT, 1, 2);                 check_err(C_NONE, 1, 2, "R8");
        idle(3); issue(ACT, 1, 2);        check_err(C_PROTO, 1, 2, "R8");
    endtask

    task automatic test_interleave();
        do_reset();
        issue(ACT, 0, 0);                 check_err(C_NONE, 0, 0, "R9");
        issue(ACT, 0, 1);                 check_err(C_NONE, 0, 1, "R9");
        issue(ACT, 1, 0);                 check_err(C_NONE, 1, 0, "R9");
        issue(ACT, 1, 3);                 check_err(C_NONE, 1, 3, "R9");
        idle(6); issue(RD, 0, 0);         check_err(C_NONE, 0, 0, "R9");
        idle(3); issue(RD, 1, 0);         check_err(C_NONE, 1, 0, "R9");
        idle(6); issue(PRE, 0, 1);        check_err(C_NONE, 0, 1, "R9");
    endtask

    // Error report and data strobe raised in the same cycle.
    task automatic test_data_overlap();
        do_reset();
        issue(ACT, 0, 3);
        idle(T_RCD - 1); issue(RD, 0, 3); check_err(C_NONE, 0, 3, "R10");
        idle(LAT - 2);
        check_data(1'b0, 0, 0, "R10");
        issue(RD, 0, 2);
        check_err(C_PROTO, 0, 2, "R10");
        check_data(1'b1, 0, 3, "R10");
        idle(1);
        check_data(1'b0, 0, 0, "R10");
        idle(LAT - 2);
        check_data(1'b1, 0, 2, "R10");
    endtask

    task automatic test_saturate();
        do_reset();
        issue(ACT, 1, 0);
        idle(100); issue(RD, 1, 0);       check_err(C_NONE, 1, 0, "R11");
        idle(70);  issue(PRE, 1, 0);      check_err(C_NONE, 1, 0, "R11");
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        rst      = 1'b1;
        cmd_op   = 2'd0;
        cmd_dev  = '0;
        cmd_bank = '0;
        @(negedge clk);
        test_reset();
        test_legal_boundaries();
        test_rcd();
        test_cc();
        test_ras();
        test_rdp();
        test_rc_rp();
        test_proto();
        test_interleave();
        test_data_overlap();
        test_saturate();
        done = 1'b1;
        report();
        $finish;
    end
endmodule